// File: doc/BRIEF.md
# Fully Associative Branch Target Cache

This block is a small fully associative cache that sits beside the fetch stage. Each cycle the fetch address is compared against every stored branch address at once. On a match the block returns the stored destination in the same cycle, so the fetch stage can steer the next fetch straight to the taken path with no lost cycle.

Entries are written from a resolution-side update port that carries a branch address, its destination and a taken/untaken prediction flag. Only branches predicted taken are kept. An untaken report for a branch that is present removes its entry, so the space serves only branches that will redirect fetch. A flush input and a synchronous reset empty the whole table.

Addresses are treated as word aligned: the two low address bits take no part in matching, and returned destinations have their two low bits forced to zero.

Top module: `branch_target_cache`

## Requirements
- R1: The table holds ENTRIES (default 32) branches, and any stored branch can be found regardless of which slot holds it. All ENTRIES slots can hold distinct branches at the same time.
- R2: A lookup is combinational. When lkAddr matches a valid entry, lkHit is 1 and lkTarget is that entry's destination in the same cycle. A taken update (updValid=1, updTaken=1) for an absent address creates an entry that lookups see from the next cycle.
- R3: An update with updTaken=0 never creates an entry.
- R4: An update with updTaken=0 whose address is present invalidates that entry from the next cycle. Other entries are unaffected.
- R5: A taken update for an address that is already present rewrites the destination in that same entry. It occupies no additional slot and does not advance the replacement pointer.
- R6: When an invalid slot exists, a new entry goes into the lowest-numbered invalid slot, and no valid entry is evicted.
- R7: When all slots are valid, a new entry replaces the slot named by a round-robin pointer. The pointer is 0 after reset or flush and advances by one, wrapping, on each such eviction only.
- R8: While flush is 1, lkHit is 0 and any update is ignored. From the next cycle, all entries are invalid.
- R9: A synchronous reset (rst=1 at a clock edge) invalidates all entries.
- R10: When an update and a lookup hit the same address in one cycle, the lookup returns the contents from before the update.
- R11: Address bits [1:0] are ignored in matching on both ports. lkTarget[1:0] is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Invalidate every entry; blocks lookup hits and updates this cycle |
| lkAddr | input | ADDR_W | Current fetch address |
| lkHit | output | 1 | Fetch address matches a valid entry |
| lkTarget | output | ADDR_W | Stored destination of the matching entry |
| updValid | input | 1 | Update port carries a resolved branch |
| updAddr | input | ADDR_W | Address of the resolved branch |
| updTarget | input | ADDR_W | Destination of the resolved branch |
| updTaken | input | 1 | 1 = predicted taken (insert or rewrite), 0 = predicted untaken (remove) |

## Verification
The bench fills every slot and then checks replacement. The lowest free slot must be reused before any valid branch is evicted, and once the table is full the victims must follow the round-robin pointer from slot 0. A design that evicted while space remained, or picked the wrong victim, would lose a branch that should still hit. A rewrite of a present branch must change only that branch's destination; a design that duplicated the entry, or advanced the pointer on a rewrite, would evict the wrong slot later. The bench also hits the same address from both ports in one cycle, where a design with write-through would return the new destination too early. It checks that removals and flushes really leave the branch missing, that untaken reports never allocate, and that low address bits play no part in matching.

// File: rtl/btc_pkg.sv
package btc_pkg;

  // Widest slot index carried in the strobe bundle (supports up to 256 slots).
  localparam int unsigned IDX_MAX_W = 8;

  // Strobes from control to storage for one cycle.
  typedef struct packed {
    logic                 wrEn;    // write tag and destination, set valid
    logic [IDX_MAX_W-1:0] wrIdx;
    logic                 clrEn;   // clear one valid bit
    logic [IDX_MAX_W-1:0] clrIdx;
    logic                 clrAll;  // clear every valid bit
  } btc_strobe_t;

endpackage

// File: rtl/btc_store.sv
module btc_store
  import btc_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned TAG_W   = 62
) (
  input  logic              clk,
  input  logic              rst,
  input  btc_strobe_t       stb,
  input  logic [TAG_W-1:0]  lkTag,
  input  logic [TAG_W-1:0]  updTag,
  input  logic [TAG_W-1:0]  updTgt,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] updMatch,
  output logic              lkHitRaw,
  output logic [TAG_W-1:0]  lkTgt
);

  logic [TAG_W-1:0]   tagArr [ENTRIES];
  logic [TAG_W-1:0]   tgtArr [ENTRIES];
  logic [ENTRIES-1:0] lkMatch;

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (rst || stb.clrAll) begin
        validVec[i] <= 1'b0;
      end else if (stb.wrEn && stb.wrIdx == IDX_MAX_W'(i)) begin
        validVec[i] <= 1'b1;
        tagArr[i]   <= updTag;
        tgtArr[i]   <= updTgt;
      end else if (stb.clrEn && stb.clrIdx == IDX_MAX_W'(i)) begin
        validVec[i] <= 1'b0;
      end
    end
  end

  // Parallel compare of every slot against both ports.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lkMatch[g]  = validVec[g] && (tagArr[g] == lkTag);
    assign updMatch[g] = validVec[g] && (tagArr[g] == updTag);
  end

  assign lkHitRaw = |lkMatch;

  // At most one slot matches, so an AND-OR mux selects the destination.
  always_comb begin
    lkTgt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lkTgt = lkTgt | (tgtArr[i] & {TAG_W{lkMatch[i]}});
    end
  end

endmodule

// File: rtl/btc_ctrl.sv
module btc_ctrl
  import btc_pkg::*;
#(
  parameter int unsigned ENTRIES = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               updValid,
  input  logic               updTaken,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] updMatch,
  output btc_strobe_t        stb
);

  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] matchIdx;
  logic             anyFree;
  logic             anyMatch;
  logic             evict;

  // Lowest-numbered invalid slot; index of the matching slot.
  always_comb begin
    freeIdx  = '0;
    matchIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) freeIdx = IDX_W'(i);
      if (updMatch[i])  matchIdx = IDX_W'(i);
    end
  end

  assign anyFree  = ~&validVec;
  assign anyMatch = |updMatch;

  always_comb begin
    stb        = '0;
    evict      = 1'b0;
    stb.clrAll = flush;
    if (updValid && !flush) begin
      if (updTaken) begin
        stb.wrEn = 1'b1;
        if (anyMatch) begin
          stb.wrIdx = IDX_MAX_W'(matchIdx);
        end else if (anyFree) begin
          stb.wrIdx = IDX_MAX_W'(freeIdx);
        end else begin
          stb.wrIdx = IDX_MAX_W'(rrPtr);
          evict     = 1'b1;
        end
      end else if (anyMatch) begin
        stb.clrEn  = 1'b1;
        stb.clrIdx = IDX_MAX_W'(matchIdx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rrPtr <= '0;
    end else if (evict) begin
      rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end

endmodule

// File: rtl/branch_target_cache.sv
module branch_target_cache
  import btc_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned ADDR_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              lkHit,
  output logic [ADDR_W-1:0] lkTarget,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic [ADDR_W-1:0] updTarget,
  input  logic              updTaken
);

  localparam int unsigned TAG_W = ADDR_W - 2;

  btc_strobe_t        stb;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] updMatch;
  logic               lkHitRaw;
  logic [TAG_W-1:0]   lkTgt;
  logic               unusedLowBits;

  assign unusedLowBits = ^{lkAddr[1:0], updAddr[1:0], updTarget[1:0]};

  btc_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .updValid (updValid),
    .updTaken (updTaken),
    .validVec (validVec),
    .updMatch (updMatch),
    .stb      (stb)
  );

  btc_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .lkTag    (lkAddr[ADDR_W-1:2]),
    .updTag   (updAddr[ADDR_W-1:2]),
    .updTgt   (updTarget[ADDR_W-1:2]),
    .validVec (validVec),
    .updMatch (updMatch),
    .lkHitRaw (lkHitRaw),
    .lkTgt    (lkTgt)
  );

  assign lkHit    = lkHitRaw && !flush;
  assign lkTarget = {lkTgt, 2'b00};

endmodule

// File: rtl/btc_checker.sv
module btc_checker #(
  parameter int unsigned ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic [ADDR_W-1:0] lkAddr,
  input logic              lkHit,
  input logic [ADDR_W-1:0] lkTarget,
  input logic              updValid,
  input logic [ADDR_W-1:0] updAddr,
  input logic [ADDR_W-1:0] updTarget,
  input logic              updTaken
);

  AST_INSERT_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && updValid && updTaken && !flush) && !flush &&
     lkAddr[ADDR_W-1:2] == $past(updAddr[ADDR_W-1:2]))
    |-> (lkHit && lkTarget[ADDR_W-1:2] == $past(updTarget[ADDR_W-1:2]))); // R2

  AST_REMOVE_MISS: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && updValid && !updTaken && !flush) &&
     lkAddr[ADDR_W-1:2] == $past(updAddr[ADDR_W-1:2]))
    |-> !lkHit); // R4

  AST_FLUSH_NOHIT: assert property (@(posedge clk) disable iff (rst)
    flush |-> !lkHit); // R8

  AST_EMPTY_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst || flush) |-> !lkHit); // R9

  AST_TGT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    lkHit |-> lkTarget[1:0] == 2'b00); // R11

endmodule

bind branch_target_cache btc_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/branch_target_cache_tb.sv
module branch_target_cache_tb;

  localparam int unsigned ADDR_W  = 64;
  localparam int unsigned ENTRIES = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              flush = 1'b0;
  logic [ADDR_W-1:0] lkAddr = '0;
  logic              lkHit;
  logic [ADDR_W-1:0] lkTarget;
  logic              updValid = 1'b0;
  logic [ADDR_W-1:0] updAddr = '0;
  logic [ADDR_W-1:0] updTarget = '0;
  logic              updTaken = 1'b0;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  branch_target_cache #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .flush(flush),
    .lkAddr(lkAddr), .lkHit(lkHit), .lkTarget(lkTarget),
    .updValid(updValid), .updAddr(updAddr), .updTarget(updTarget),
    .updTaken(updTaken)
  );

  // op: 0 idle, 1 taken update, 2 untaken update. Lookup checked before the edge.
  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] ua;
    logic [15:0] ut;
    logic [15:0] la;
    logic        eh;
    logic [15:0] et;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 16'h0100, 16'h0000, 16'h0100, 1'b0, 16'h0000, 4'd9},  // R9 empty after reset
    '{2'd1, 16'h0100, 16'h0800, 16'h0100, 1'b0, 16'h0000, 4'd10}, // R10 same-cycle insert unseen
    '{2'd0, 16'h0000, 16'h0000, 16'h0100, 1'b1, 16'h0800, 4'd2},  // R2 visible next cycle
    '{2'd0, 16'h0000, 16'h0000, 16'h0103, 1'b1, 16'h0800, 4'd11}, // R11 low lookup bits ignored
    '{2'd2, 16'h0200, 16'h0900, 16'h0200, 1'b0, 16'h0000, 4'd3},  // R3
    '{2'd0, 16'h0000, 16'h0000, 16'h0200, 1'b0, 16'h0000, 4'd3},  // R3 untaken not inserted
    '{2'd1, 16'h0100, 16'h0A00, 16'h0100, 1'b1, 16'h0800, 4'd10}, // R10 old target seen
    '{2'd0, 16'h0000, 16'h0000, 16'h0100, 1'b1, 16'h0A00, 4'd5},  // R5 rewritten target
    '{2'd1, 16'h0300, 16'h0B03, 16'h0300, 1'b0, 16'h0000, 4'd10}, // R10
    '{2'd0, 16'h0000, 16'h0000, 16'h0300, 1'b1, 16'h0B00, 4'd11}, // R11 target low bits zero
    '{2'd2, 16'h0102, 16'h0000, 16'h0100, 1'b1, 16'h0A00, 4'd10}, // R10 removal not yet seen
    '{2'd0, 16'h0000, 16'h0000, 16'h0100, 1'b0, 16'h0000, 4'd4},  // R4 removed
    '{2'd0, 16'h0000, 16'h0000, 16'h0300, 1'b1, 16'h0B00, 4'd4}   // R4 others intact
  };

  task automatic drive(input logic [1:0] op, input logic [ADDR_W-1:0] ua,
                       input logic [ADDR_W-1:0] ut, input logic [ADDR_W-1:0] la,
                       input logic fl);
    @(negedge clk);
    updValid  = (op != 2'd0);
    updTaken  = (op == 2'd1);
    updAddr   = ua;
    updTarget = ut;
    lkAddr    = la;
    flush     = fl;
    #1;
  endtask

  task automatic check(input logic eh, input logic [ADDR_W-1:0] et, input string req);
    total++;
    if (lkHit !== eh || (eh && lkTarget !== et)) begin
      bad++;
      $display("FAIL %s: hit=%0b target=%h expected hit=%0b target=%h",
               req, lkHit, lkTarget, eh, et);
    end
  endtask

  task automatic look(input logic [ADDR_W-1:0] la, input logic eh,
                      input logic [ADDR_W-1:0] et, input string req);
    drive(2'd0, '0, '0, la, 1'b0);
    check(eh, et, req);
  endtask

  function automatic logic [ADDR_W-1:0] aAddr(input int i);
    return ADDR_W'(64'h1000 + i * 16);
  endfunction

  function automatic logic [ADDR_W-1:0] aTgt(input int i);
    return ADDR_W'(64'h8000 + i * 4);
  endfunction

  initial begin
    int failsBefore;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // Table-driven sequence
    for (int k = 0; k < NV; k++) begin
      drive(VEC[k].op, ADDR_W'(VEC[k].ua), ADDR_W'(VEC[k].ut), ADDR_W'(VEC[k].la), 1'b0);
      check(VEC[k].eh, ADDR_W'(VEC[k].et), $sformatf("R%0d vec%0d", VEC[k].req, k));
    end

    // R8: flush blocks the lookup and the update in its cycle, then table empty
    drive(2'd1, 64'h400, 64'hC00, 64'h300, 1'b1);
    check(1'b0, '0, "R8 lookup during flush");
    look(64'h300, 1'b0, '0, "R8 entry gone after flush");
    look(64'h400, 1'b0, '0, "R8 update during flush ignored");

    // R1/R6: fill every slot on an empty table
    for (int i = 0; i < ENTRIES; i++) drive(2'd1, aAddr(i), aTgt(i), '0, 1'b0);
    for (int i = 0; i < ENTRIES; i++) look(aAddr(i), 1'b1, aTgt(i), $sformatf("R1 slot%0d", i));

    // R6: removing one frees a slot that the next insert reuses without eviction
    drive(2'd2, aAddr(5), '0, '0, 1'b0);
    drive(2'd1, 64'h5000, 64'hE000, '0, 1'b0);
    look(64'h5000, 1'b1, 64'hE000, "R6 new entry");
    failsBefore = bad;
    for (int i = 0; i < ENTRIES; i++)
      if (i != 5) look(aAddr(i), 1'b1, aTgt(i), $sformatf("R6 kept %0d", i));
    look(aAddr(5), 1'b0, '0, "R6 removed entry stays gone");

    // R5: rewriting a present branch takes no slot and keeps pointer
    drive(2'd1, aAddr(10), 64'hF000, '0, 1'b0);
    look(aAddr(10), 1'b1, 64'hF000, "R5 rewrite target");
    look(aAddr(0), 1'b1, aTgt(0), "R5 rewrite evicted nothing");

    // R7: full table, victims follow pointer 0,1,2
    drive(2'd1, 64'h6000, 64'hD000, '0, 1'b0);
    look(aAddr(0), 1'b0, '0, "R7 slot0 evicted first");
    look(aAddr(1), 1'b1, aTgt(1), "R7 slot1 still present");
    drive(2'd1, 64'h6010, 64'hD010, '0, 1'b0);
    look(aAddr(1), 1'b0, '0, "R7 slot1 evicted second");
    look(aAddr(2), 1'b1, aTgt(2), "R7 slot2 still present");
    drive(2'd1, 64'h6020, 64'hD020, '0, 1'b0);
    look(aAddr(2), 1'b0, '0, "R7 slot2 evicted third");
    look(64'h6000, 1'b1, 64'hD000, "R7 first newcomer present");
    look(64'h6010, 1'b1, 64'hD010, "R7 second newcomer present");
    look(64'h6020, 1'b1, 64'hD020, "R7 third newcomer present");
    look(64'h5000, 1'b1, 64'hE000, "R7 reused slot kept");
    look(aAddr(10), 1'b1, 64'hF000, "R5 rewritten entry kept");
    look(aAddr(3), 1'b1, aTgt(3), "R7 slot3 untouched");

    // R9: synchronous reset mid-run
    @(negedge clk);
    rst = 1'b1;
    updValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    look(64'h6000, 1'b0, '0, "R9 reset clears entries");
    look(aAddr(3), 1'b0, '0, "R9 reset clears entries");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule